// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Display Driver

This block shows two independent 4-bit values as two hex digits on a dual seven-segment display that has one shared set of seven segment lines. A single hex-to-segment decoder serves both digits: a slow select signal, produced by dividing the system clock, alternates which value reaches the decoder, and a two-bit active-low digit enable lights only the digit whose value is currently on the segment lines. At a swap rate near 60 Hz the eye sees both digits at once.

Alongside the display, the block presents the unsigned 5-bit sum of the two values for a row of LEDs. The clock frequency and the swap rate are parameters; the divide ratio `DIV = CLK_HZ / TOGGLE_HZ` sets how many clock cycles each digit stays lit.

Top module: `hexpair_display`

## Requirements
- R1: While `rst_n` is low (asynchronous), `dig_en_n` is 2'b10 and the divider is cleared; after release, digit 0 (`val_a`) is shown for the first DIV rising edges.
- R2: `seg_n` is the bitwise complement of the pattern of the selected value, bit order {g,f,e,d,c,b,a}, active-high patterns in hex for 0..F: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R3: Exactly one bit of `dig_en_n` is low at all times after reset; bit 0 low means `val_a` is on the segments, bit 1 low means `val_b`.
- R4: The selected digit holds for exactly DIV rising edges and then swaps, so the enable pattern has period 2*DIV.
- R5: The value of the digit that is not selected has no effect on `seg_n`.
- R6: `sum` equals `val_a + val_b` as an unsigned 5-bit number (0 to 30) in every cycle, independent of which digit is shown.
- R7: The sixteen segment patterns are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| val_a | input | 4 | Value shown on digit 0 |
| val_b | input | 4 | Value shown on digit 1 |
| seg_n | output | 7 | Shared segment lines, active low, {g,f,e,d,c,b,a} |
| dig_en_n | output | 2 | Digit enables, active low, one low at a time |
| sum | output | 5 | Unsigned sum of val_a and val_b |

## Verification
The digit swap and a change of the input values can land on the same clock edge, and the sum must move with the inputs while the segment lines move with both. The bench runs with a short divide ratio of 10 and steps seven cycles between vectors, so input changes drift across the swap edges and fall on both phases and on the swap itself. Each sample is judged against the select phase the bench derives from its own count of edges since reset, with the sum checked in the same sample.

// File: rtl/hexpair_pkg.sv
package hexpair_pkg;

  localparam int NUM_DIGITS = 2;
  localparam int SEL_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  typedef logic [3:0] nibble_t;
  typedef logic [6:0] seg_t;

  // Active-high segment pattern, bit order {g,f,e,d,c,b,a}
  function automatic seg_t hex_pattern(input nibble_t v);
    seg_t p;
    case (v)
      4'h0: p = 7'h3F;
      4'h1: p = 7'h06;
      4'h2: p = 7'h5B;
      4'h3: p = 7'h4F;
      4'h4: p = 7'h66;
      4'h5: p = 7'h6D;
      4'h6: p = 7'h7D;
      4'h7: p = 7'h07;
      4'h8: p = 7'h7F;
      4'h9: p = 7'h6F;
      4'hA: p = 7'h77;
      4'hB: p = 7'h7C;
      4'hC: p = 7'h39;
      4'hD: p = 7'h5E;
      4'hE: p = 7'h79;
      default: p = 7'h71;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hexpair_divider.sv
module hexpair_divider #(
  parameter int CLK_HZ    = 12_000_000,
  parameter int TOGGLE_HZ = 60,
  parameter int SEL_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEL_W-1:0] sel_o
);

  localparam int DIV_RAW = CLK_HZ / TOGGLE_HZ;
  localparam int DIV     = (DIV_RAW < 2) ? 2 : DIV_RAW;
  localparam int CNT_W   = $clog2(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             wrap_w;

  assign wrap_w = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    sel_d = sel_q;
    if (wrap_w) begin
      cnt_d = '0;
      sel_d = sel_q + SEL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/hexpair_digit_sel.sv
module hexpair_digit_sel
  import hexpair_pkg::*;
#(
  parameter int N = NUM_DIGITS,
  parameter int W = SEL_W
) (
  input  nibble_t [N-1:0] vals_i,
  input  logic [W-1:0]    sel_i,
  output nibble_t         val_o,
  output logic [N-1:0]    en_n_o
);

  logic [N-1:0] hit_w;

  for (genvar i = 0; i < N; i++) begin : g_dig
    assign hit_w[i]  = (sel_i == W'(i));
    assign en_n_o[i] = ~hit_w[i];
  end

  always_comb begin
    val_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_w[i]) val_o = vals_i[i];
    end
  end

endmodule

// File: rtl/hexpair_seg_decoder.sv
module hexpair_seg_decoder
  import hexpair_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  nibble_t val_i,
  output seg_t    seg_o
);

  seg_t pat_w;
  assign pat_w = hex_pattern(val_i);

  if (ACTIVE_LOW) begin : g_low
    assign seg_o = ~pat_w;
  end else begin : g_high
    assign seg_o = pat_w;
  end

endmodule

// File: rtl/hexpair_display.sv
module hexpair_display
  import hexpair_pkg::*;
#(
  parameter int CLK_HZ    = 12_000_000,
  parameter int TOGGLE_HZ = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] val_a,
  input  logic [3:0] val_b,
  output logic [6:0] seg_n,
  output logic [1:0] dig_en_n,
  output logic [4:0] sum
);

  logic [SEL_W-1:0]      sel_w;
  nibble_t [NUM_DIGITS-1:0] vals_w;
  nibble_t               shown_w;

  assign vals_w[0] = val_a;
  assign vals_w[1] = val_b;

  hexpair_divider #(
    .CLK_HZ   (CLK_HZ),
    .TOGGLE_HZ(TOGGLE_HZ),
    .SEL_W    (SEL_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .sel_o(sel_w)
  );

  hexpair_digit_sel #(
    .N(NUM_DIGITS),
    .W(SEL_W)
  ) u_sel (
    .vals_i(vals_w),
    .sel_i (sel_w),
    .val_o (shown_w),
    .en_n_o(dig_en_n)
  );

  hexpair_seg_decoder #(
    .ACTIVE_LOW(1'b1)
  ) u_dec (
    .val_i(shown_w),
    .seg_o(seg_n)
  );

  assign sum = {1'b0, val_a} + {1'b0, val_b};

endmodule

// File: rtl/hexpair_display_chk.sv
module hexpair_display_chk #(
  parameter int CLK_HZ    = 12_000_000,
  parameter int TOGGLE_HZ = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] val_a,
  input logic [3:0] val_b,
  input logic [6:0] seg_n,
  input logic [1:0] dig_en_n,
  input logic [4:0] sum
);

  localparam int DIV_RAW = CLK_HZ / TOGGLE_HZ;
  localparam int DIV     = (DIV_RAW < 2) ? 2 : DIV_RAW;

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (run_q == DIV - 1)  run_q <= '0;
    else                        run_q <= run_q + 32'd1;
  end

  a_r1_first_digit: assert property (@(posedge clk)
    $rose(rst_n) |-> (dig_en_n == 2'b10));

  a_r3_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) == 1);

  a_r4_swap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == DIV - 1) |=> (dig_en_n != $past(dig_en_n)));

  a_r4_hold_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != DIV - 1) |=> $stable(dig_en_n));

  a_r5_ignore_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!dig_en_n[0] && $past(!dig_en_n[0]) && $stable(val_a)) |-> $stable(seg_n));

  a_r5_ignore_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!dig_en_n[1] && $past(!dig_en_n[1]) && $stable(val_b)) |-> $stable(seg_n));

  a_r6_sum_phase_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(val_a) && $stable(val_b)) |-> $stable(sum));

endmodule

bind hexpair_display hexpair_display_chk #(
  .CLK_HZ   (CLK_HZ),
  .TOGGLE_HZ(TOGGLE_HZ)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .val_a   (val_a),
  .val_b   (val_b),
  .seg_n   (seg_n),
  .dig_en_n(dig_en_n),
  .sum     (sum)
);

// File: tb/hexpair_display_tb.sv
module hexpair_display_tb;

  localparam int CLK_HZ    = 1000;
  localparam int TOGGLE_HZ = 100;
  localparam int DIV       = CLK_HZ / TOGGLE_HZ;
  localparam int NVEC      = 12;

  // {val_a, val_b}
  localparam logic [7:0] VEC [NVEC] = '{
    8'h00, 8'h12, 8'hF0, 8'h0F, 8'hFF, 8'h8E,
    8'hA5, 8'h3C, 8'h79, 8'hD4, 8'hB6, 8'h1F
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] val_a = 4'h0;
  logic [3:0] val_b = 4'h0;
  logic [6:0] seg_n;
  logic [1:0] dig_en_n;
  logic [4:0] sum;

  int checks = 0;
  int errors = 0;
  int edges;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hexpair_display #(.CLK_HZ(CLK_HZ), .TOGGLE_HZ(TOGGLE_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .val_a(val_a), .val_b(val_b),
    .seg_n(seg_n), .dig_en_n(dig_en_n), .sum(sum)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  function automatic logic [6:0] pat(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int ph;
    logic [1:0] en_exp;
    logic [6:0] seg_exp;
    ph      = (edges / DIV) % 2;
    en_exp  = (ph == 0) ? 2'b10 : 2'b01;
    seg_exp = ~pat((ph == 0) ? val_a : val_b);
    chk(dig_en_n == en_exp, {"R3/R4 ", tag}, dig_en_n, en_exp);
    chk(seg_n == seg_exp, {"R2 ", tag}, seg_n, seg_exp);
    chk(sum == 5'(val_a) + 5'(val_b), {"R6 ", tag}, sum, 5'(val_a) + 5'(val_b));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [6:0] seen [16];
    repeat (3) @(negedge clk);
    // R1: reset state
    val_a = 4'h5; val_b = 4'hC; #1;
    chk(dig_en_n == 2'b10, "R1 reset enable", dig_en_n, 2'b10);
    chk(seg_n == ~pat(4'h5), "R1 reset shows val_a", seg_n, ~pat(4'h5));
    @(negedge clk); rst_n = 1'b1;

    // R1/R4: first DIV edges show digit 0, then swap, over three phases
    for (int k = 0; k < 3 * DIV; k++) begin
      @(negedge clk); #1;
      check_all("R4 phase walk");
    end

    // Vector table, stepping 7 cycles so changes land on both phases and swaps
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {val_a, val_b} = VEC[i]; #1;
      check_all("vector");
      repeat (7) @(posedge clk);
      @(negedge clk); #1;
      check_all("vector later");
    end

    // R5: unselected digit changes leave segments untouched
    while (((edges / DIV) % 2) != 0 || (edges % DIV) > DIV - 4) @(negedge clk);
    val_a = 4'h9; #1;
    for (int v = 0; v < 3; v++) begin
      val_b = 4'(v * 5 + 1); #1;
      chk(seg_n == ~pat(4'h9), "R5 val_b ignored", seg_n, ~pat(4'h9));
    end
    while (((edges / DIV) % 2) != 1 || (edges % DIV) > DIV - 4) @(negedge clk);
    val_b = 4'hE; #1;
    for (int v = 0; v < 3; v++) begin
      val_a = 4'(v * 3 + 2); #1;
      chk(seg_n == ~pat(4'hE), "R5 val_a ignored", seg_n, ~pat(4'hE));
    end

    // R2/R7: sweep all values on digit 0 and check distinctness
    @(negedge clk); rst_n = 1'b0; #1;
    @(negedge clk); rst_n = 1'b1;
    for (int v = 0; v < 16; v++) begin
      val_a = 4'(v); #1;
      seen[v] = ~seg_n;
      chk(seg_n == ~pat(4'(v)), "R2 sweep", seg_n, ~pat(4'(v)));
    end
    for (int x = 0; x < 16; x++)
      for (int y = x + 1; y < 16; y++)
        if (seen[x] == seen[y]) chk(1'b0, "R7 distinct", seen[x], seen[y]);
    chk(1'b1, "R7 distinct", 0, 0);

    // R1: asynchronous reset in the middle of digit-1 phase
    while (((edges / DIV) % 2) != 1) @(negedge clk);
    val_a = 4'h3; val_b = 4'hA;
    #5 rst_n = 1'b0; #1;
    chk(dig_en_n == 2'b10, "R1 async reset", dig_en_n, 2'b10);
    chk(seg_n == ~pat(4'h3), "R1 async reset seg", seg_n, ~pat(4'h3));
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < DIV + 2; k++) begin
      @(negedge clk); #1;
      check_all("R1 after release");
    end

    finish_up();
  end

endmodule